// File: doc/BRIEF.md
# 4B5B Receive Carrier Sense Detector

This block watches a 100 Mb/s receive stream that has already been descrambled but not yet decoded. It takes one 5-bit code-group bit per clock and produces the carrier-sense indication for the MAC side. A loose zero-density rule raises an early carrier on any line activity. If no start-of-stream delimiter arrives, a run of ones withdraws it. Once the J/K delimiter pair is found, the block locks symbol alignment and follows the frame one code group at a time. It ends the carrier on a T/R end delimiter or on a pair of IDLE groups.

Negation depends on the code group that follows T or the first IDLE. The receive carrier is therefore issued through a delay of one symbol, five bit clocks, plus one output register. When a terminating second group completes, the delayed copy of that group is wiped. The output carrier then falls exactly on the boundary after T, or after the first IDLE. The final output is the delayed receive carrier alone when the link is full-duplex or the device acts as a repeater. Otherwise the output also includes the local transmit enable. A link-down input forces the detector back to its quiet state.

Top module: `crs_4b5b_detect`

## Requirements
- R1: With no carrier present, two zero bits at least two positions apart inside the latest 10 received bits raise the receive carrier.
- R2: Zeros that only sit next to each other, or that are 10 or more positions apart, do not raise the carrier.
- R3: An early carrier that has seen no start delimiter is withdrawn once the latest 10 received bits are all ones.
- R4: The bit pattern 1100010001 (J = 11000 then K = 10001, first bit received first) starts a frame. Symbol boundaries then fall every five bits after it. The carrier then holds through any code groups, including long runs of ones, until a termination rule fires.
- R5: T (01101) followed directly by R (00111) ends the frame. The carrier covers the T group and is low for the R group.
- R6: Two consecutive IDLE groups (11111) end the frame. The carrier covers the first IDLE and is low from the second.
- R7: T followed by any group other than R, and IDLE followed by any non-IDLE group, leave the carrier asserted.
- R8: When `full_duplex` or `repeater_mode` is high, `crs` equals the receive carrier regardless of `tx_en`.
- R9: When both mode inputs are low, `crs` is the OR of the receive carrier and `tx_en`.
- R10: Reset and `link_down` return the detector to the quiet state. Both outputs read 0 after reset, and from the second clock of `link_down`.
- Timing: `rx_carrier` after clock edge k carries the carrier value of the bit sampled at edge k-5. `crs` combines that value with `tx_en` sampled at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_code_bit | input | 1 | Descrambled code-group bit, first bit of each group first |
| tx_en | input | 1 | Local transmit enable |
| full_duplex | input | 1 | Link runs full duplex |
| repeater_mode | input | 1 | Device operates as a repeater |
| link_down | input | 1 | Forces the detector to the quiet state |
| rx_carrier | output | 1 | Delayed receive carrier alone |
| crs | output | 1 | Carrier sense after mode merge |

## Verification
Carrier negation at an end delimiter and the transmit-enable merge can land in the same output cycle. In that cycle the wiped receive carrier must fall while `tx_en` may hold `crs` high. The bench provokes this by replaying complete frames under all four mode-input combinations, with a `tx_en` pattern of period seven. That pattern is high at several of the boundary cycles. Every sampled output is judged against a carrier timeline that the bench derives from the stream on its own, ORed with the sampled `tx_en` only when both mode inputs are low.

// File: rtl/crs4b5b_pkg.sv
package crs4b5b_pkg;
  localparam int SYM_BITS = 5;
  localparam logic [SYM_BITS-1:0] CG_J    = 5'b11000;
  localparam logic [SYM_BITS-1:0] CG_K    = 5'b10001;
  localparam logic [SYM_BITS-1:0] CG_T    = 5'b01101;
  localparam logic [SYM_BITS-1:0] CG_R    = 5'b00111;
  localparam logic [SYM_BITS-1:0] CG_IDLE = 5'b11111;
  typedef enum logic [1:0] {TRK_IDLE, TRK_PRE, TRK_STREAM} trk_state_e;
endpackage

// File: rtl/crs_code_window.sv
module crs_code_window #(
  parameter int WIN_BITS = 10,
  parameter int ONES_RUN = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                bit_in,
  output logic [WIN_BITS-1:0] win_next,
  output logic                zero_pair,
  output logic                ones_run
);
  logic [WIN_BITS-1:0] win_q;

  // newest bit at index 0, oldest at the top
  assign win_next = {win_q[WIN_BITS-2:0], bit_in};
  assign ones_run = &win_next[ONES_RUN-1:0];

  // two zeros separated by at least one position
  always_comb begin
    zero_pair = 1'b0;
    for (int i = 0; i < WIN_BITS - 2; i++) begin
      for (int j = i + 2; j < WIN_BITS; j++) begin
        if (!win_next[i] && !win_next[j]) zero_pair = 1'b1;
      end
    end
  end

  // a cleared window reads as line idle (all ones)
  always_ff @(posedge clk) begin
    if (rst || clr) win_q <= '1;
    else            win_q <= win_next;
  end
endmodule

// File: rtl/crs_stream_tracker.sv
module crs_stream_tracker
  import crs4b5b_pkg::*;
#(
  parameter int WIN_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                link_down,
  input  logic [WIN_BITS-1:0] win_next,
  input  logic                zero_pair,
  input  logic                ones_run,
  output logic                push_val,
  output logic                flush
);
  localparam int CNT_W = $clog2(SYM_BITS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(SYM_BITS - 1);

  trk_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SYM_BITS-1:0] cur_sym, prev_sym;
  logic jk_hit, sym_done, term;

  assign cur_sym  = win_next[SYM_BITS-1:0];
  assign prev_sym = win_next[2*SYM_BITS-1:SYM_BITS];
  assign jk_hit   = (win_next[2*SYM_BITS-1:0] == {CG_J, CG_K});
  assign sym_done = (state_q == TRK_STREAM) && (cnt_q == LAST_POS);
  assign term     = ((prev_sym == CG_T)    && (cur_sym == CG_R)) ||
                    ((prev_sym == CG_IDLE) && (cur_sym == CG_IDLE));
  assign flush    = sym_done && term;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      TRK_IDLE: begin
        if (jk_hit) begin
          state_d = TRK_STREAM;
          cnt_d   = '0;
        end else if (zero_pair) begin
          state_d = TRK_PRE;
        end
      end
      TRK_PRE: begin
        if (jk_hit) begin
          state_d = TRK_STREAM;
          cnt_d   = '0;
        end else if (ones_run) begin
          state_d = TRK_IDLE;
        end
      end
      TRK_STREAM: begin
        if (sym_done) begin
          cnt_d = '0;
          if (term) state_d = TRK_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = TRK_IDLE;
    endcase
    if (link_down) begin
      state_d = TRK_IDLE;
      cnt_d   = '0;
    end
  end

  assign push_val = (state_d != TRK_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TRK_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_ZERO_PAIR_WAKES: assert property (@(posedge clk) disable iff (rst)
    (state_q == TRK_IDLE && zero_pair && !link_down) |=> (state_q != TRK_IDLE)); // R1
  AST_QUIET_STAYS: assert property (@(posedge clk) disable iff (rst)
    (state_q == TRK_IDLE && !zero_pair && !jk_hit) |=> (state_q == TRK_IDLE)); // R2
  AST_ONES_DROP: assert property (@(posedge clk) disable iff (rst)
    (state_q == TRK_PRE && ones_run && !jk_hit) |=> (state_q == TRK_IDLE)); // R3
  AST_LINK_DOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
    link_down |=> (state_q == TRK_IDLE && cnt_q == '0)); // R10
endmodule

// File: rtl/crs_out_stage.sv
module crs_out_stage #(
  parameter int DEPTH = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic push_val,
  input  logic tx_en,
  input  logic rx_only,
  output logic rx_carrier,
  output logic crs
);
  logic [DEPTH-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q      <= '0;
      rx_carrier <= 1'b0;
      crs        <= 1'b0;
    end else begin
      dly_q      <= clr ? '0 : {dly_q[DEPTH-2:0], push_val};
      rx_carrier <= dly_q[DEPTH-1];
      crs        <= dly_q[DEPTH-1] | (tx_en & ~rx_only);
    end
  end

  AST_RX_ONLY_MODE: assert property (@(posedge clk) disable iff (rst)
    rx_only |=> (crs == rx_carrier)); // R8
  AST_TX_MERGE: assert property (@(posedge clk) disable iff (rst)
    (tx_en && !rx_only) |=> crs); // R9
  AST_CRS_COVERS_RX: assert property (@(posedge clk) disable iff (rst)
    rx_carrier |-> crs); // R9
endmodule

// File: rtl/crs_4b5b_detect.sv
module crs_4b5b_detect
  import crs4b5b_pkg::*;
#(
  parameter int WIN_BITS = 10,
  parameter int ONES_RUN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_code_bit,
  input  logic tx_en,
  input  logic full_duplex,
  input  logic repeater_mode,
  input  logic link_down,
  output logic rx_carrier,
  output logic crs
);
  logic [WIN_BITS-1:0] win_next;
  logic zero_pair, ones_run, push_val, flush, wipe;

  assign wipe = flush | link_down;

  crs_code_window #(.WIN_BITS(WIN_BITS), .ONES_RUN(ONES_RUN)) u_window (
    .clk       (clk),
    .rst       (rst),
    .clr       (wipe),
    .bit_in    (rx_code_bit),
    .win_next  (win_next),
    .zero_pair (zero_pair),
    .ones_run  (ones_run)
  );

  crs_stream_tracker #(.WIN_BITS(WIN_BITS)) u_tracker (
    .clk       (clk),
    .rst       (rst),
    .link_down (link_down),
    .win_next  (win_next),
    .zero_pair (zero_pair),
    .ones_run  (ones_run),
    .push_val  (push_val),
    .flush     (flush)
  );

  crs_out_stage #(.DEPTH(SYM_BITS)) u_out (
    .clk        (clk),
    .rst        (rst),
    .clr        (wipe),
    .push_val   (push_val),
    .tx_en      (tx_en),
    .rx_only    (full_duplex | repeater_mode),
    .rx_carrier (rx_carrier),
    .crs        (crs)
  );
endmodule

// File: tb/crs_4b5b_detect_test.sv
module crs_4b5b_detect_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_code_bit = 1'b1;
  logic tx_en = 1'b0;
  logic full_duplex = 1'b0;
  logic repeater_mode = 1'b0;
  logic link_down = 1'b0;
  logic rx_carrier, crs;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic bits [0:511];
  logic cexp [0:511];
  int nb;

  localparam logic [4:0] S_J = 5'b11000, S_K = 5'b10001, S_T = 5'b01101,
                         S_R = 5'b00111, S_I = 5'b11111;

  crs_4b5b_detect uut (
    .clk(clk), .rst(rst), .rx_code_bit(rx_code_bit), .tx_en(tx_en),
    .full_duplex(full_duplex), .repeater_mode(repeater_mode),
    .link_down(link_down), .rx_carrier(rx_carrier), .crs(crs)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic clear_stream();
    nb = 0;
  endtask

  task automatic add_ones(int n);
    for (int i = 0; i < n; i++) begin bits[nb] = 1'b1; nb++; end
  endtask

  task automatic add_sym(logic [4:0] s);
    for (int i = 4; i >= 0; i--) begin bits[nb] = s[i]; nb++; end
  endtask

  function automatic logic getb(int i, int st);
    if (i < 0 || i < st) return 1'b1;
    return bits[i];
  endfunction

  // carrier timeline per received bit, built from the requirements
  task automatic build_model();
    int mode = 0;
    int phase = 0;
    int st = 0;
    for (int k = 0; k < nb; k++) begin
      logic [9:0] w;
      logic zp;
      for (int b = 0; b < 10; b++) w[b] = getb(k - b, st);
      zp = 1'b0;
      for (int i = 0; i < 8; i++)
        for (int j = i + 2; j < 10; j++)
          if (!w[i] && !w[j]) zp = 1'b1;
      if (mode != 2) begin
        if (w == 10'b1100010001) begin mode = 2; phase = 0; end
        else if (mode == 0 && zp) mode = 1;
        else if (mode == 1 && (&w)) mode = 0;
        cexp[k] = (mode != 0);
      end else begin
        cexp[k] = 1'b1;
        phase++;
        if (phase == 5) begin
          phase = 0;
          if ((w[9:5] == S_T && w[4:0] == S_R) || (w[9:5] == S_I && w[4:0] == S_I)) begin
            for (int q = k - 4; q <= k; q++) cexp[q] = 1'b0;
            mode = 0;
            st = k + 1;
          end
        end
      end
    end
  endtask

  task automatic do_reset(logic fd, logic rep);
    @(negedge clk);
    rst = 1'b1; rx_code_bit = 1'b1; tx_en = 1'b0; link_down = 1'b0;
    full_duplex = fd; repeater_mode = rep;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R10", "crs after reset", crs, 1'b0);
    check("R10", "rx_carrier after reset", rx_carrier, 1'b0);
  endtask

  task automatic run_stream(string tag, logic fd, logic rep, bit txp);
    logic er, ec, t;
    do_reset(fd, rep);
    build_model();
    for (int k = 0; k < nb; k++) begin
      t = txp && ((k % 7) < 3);
      rx_code_bit = bits[k];
      tx_en = t;
      @(negedge clk);
      er = (k >= 5) ? cexp[k-5] : 1'b0;
      ec = er | (t & ~(fd | rep));
      check(tag, $sformatf("rx_carrier bit %0d", k), rx_carrier, er);
      check(tag, $sformatf("crs bit %0d", k), crs, ec);
    end
  endtask

  task automatic build_frame();
    clear_stream();
    add_ones(15);
    add_sym(S_J); add_sym(S_K);
    add_sym(5'b01011); add_sym(5'b10110); add_sym(5'b11110); add_sym(5'b01001);
    add_sym(S_T); add_sym(S_R);
    add_ones(20);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog all actual=hung expected=complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R2: idle line
    clear_stream(); add_ones(30);
    run_stream("R2", 1'b0, 1'b0, 1'b0);

    // R1 / R2 / R3: sweep of the spacing between two isolated zeros
    for (int d = 1; d <= 12; d++) begin
      clear_stream();
      add_ones(12); bits[nb] = 1'b0; nb++;
      add_ones(d - 1); bits[nb] = 1'b0; nb++;
      add_ones(16);
      run_stream((d >= 2 && d <= 9) ? "R1" : "R2", 1'b0, 1'b0, 1'b0);
    end

    // R3: false carrier with no delimiter, withdrawn by ten ones
    clear_stream(); add_ones(12);
    bits[nb] = 1'b0; nb++; bits[nb] = 1'b1; nb++; bits[nb] = 1'b0; nb++;
    add_ones(3); bits[nb] = 1'b0; nb++;
    add_ones(16);
    run_stream("R3", 1'b0, 1'b0, 1'b0);

    // R4: long ones inside a frame keep the carrier
    clear_stream(); add_ones(12);
    add_sym(S_J); add_sym(S_K);
    add_sym(5'b11110); add_sym(S_I); add_sym(5'b11101); add_sym(5'b10110);
    add_sym(S_T); add_sym(S_R); add_ones(20);
    run_stream("R4", 1'b0, 1'b0, 1'b0);

    // R5: T/R ending
    build_frame();
    run_stream("R5", 1'b0, 1'b0, 1'b0);

    // R6: IDLE/IDLE ending
    clear_stream(); add_ones(12);
    add_sym(S_J); add_sym(S_K); add_sym(5'b10110); add_sym(5'b01011);
    add_sym(S_I); add_sym(S_I); add_ones(20);
    run_stream("R6", 1'b0, 1'b0, 1'b0);

    // R7: T without R, IDLE followed by data
    clear_stream(); add_ones(12);
    add_sym(S_J); add_sym(S_K); add_sym(S_T); add_sym(5'b10110);
    add_sym(S_I); add_sym(5'b01011); add_sym(S_T); add_sym(S_T);
    add_sym(S_R); add_ones(20);
    run_stream("R7", 1'b0, 1'b0, 1'b0);

    // R8 / R9: every mode combination with a transmit pattern
    for (int m = 0; m < 4; m++) begin
      build_frame();
      run_stream((m != 0) ? "R8" : "R9", logic'(m[0]), logic'(m[1]), 1'b1);
    end

    // R10: link down in the middle of a frame
    do_reset(1'b0, 1'b0);
    clear_stream(); add_ones(10);
    add_sym(S_J); add_sym(S_K); add_sym(5'b10110); add_sym(5'b01011);
    add_sym(5'b11110); add_sym(5'b01001);
    for (int k = 0; k < nb; k++) begin
      rx_code_bit = bits[k];
      @(negedge clk);
    end
    check("R10", "crs before link down", crs, 1'b1);
    rx_code_bit = 1'b1;
    link_down = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10", "crs second cycle of link down", crs, 1'b0);
    check("R10", "rx_carrier second cycle of link down", rx_carrier, 1'b0);
    link_down = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check("R10", "crs after link down", crs, 1'b0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule